// File: doc/BRIEF.md
# Fine-Grain Multithread Thread Selector

This block chooses, on every clock cycle, which one of four hardware threads may issue into a shared single-issue, in-order pipeline. Each thread is offered through a ready bit. A thread is also taken out of the running when it hits a cache miss, a trap or a resource conflict, or when it begins a long-latency operation such as a load, a branch, a multiply or a divide. It comes back only when its completion input is seen.

Among the threads that can issue, the one that was chosen longest ago wins. The block keeps a four-entry age list, from oldest to newest. A chosen thread moves to the newest end of that list only on a cycle in which the pipeline actually advances. This lets a stalled pipeline hold its choice without disturbing fairness. The selection is combinational from the current inputs and the registered state, so the pipeline sees it in the same cycle.

Top module: `mt_thread_picker`

## Requirements
- R1: After reset no thread is blocked and the age list is thread 0 (oldest), 1, 2, 3 (newest). With all ready bits set, the first selection is therefore thread 0 (sel_onehot = 4'b0001).
- R2: sel_onehot has at most one bit set, with bit i standing for thread i. sel_valid is 1 exactly when one bit is set.
- R3: A thread is selected only if its ready bit is 1 and it is not blocked.
- R4: When several threads are available, the selected thread is the one nearest the oldest end of the age list.
- R5: On a cycle with advance = 1 and sel_valid = 1, the selected thread moves to the newest position. The other threads keep their relative order.
- R6: On a cycle with advance = 0, the age list is unchanged, so with unchanged availability the same thread is selected again in the next cycle.
- R7: A pulse on ev_miss, ev_trap, ev_conflict or op_start for thread i excludes thread i in that same cycle and blocks it in later cycles. The block lasts until op_done for thread i is seen; the thread is selectable from the cycle after op_done. If a block event and op_done for the same thread arrive in the same cycle, the event wins and the thread stays blocked.
- R8: When no thread is available, sel_valid = 0 and sel_onehot = 0. The age list is left unchanged even if advance = 1.
- R9: A ready bit of 0 only hides its thread for that cycle. It does not block the thread, and it does not change the thread's age position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| thr_ready | input | 4 | Per-thread ready bit for this cycle |
| ev_miss | input | 4 | Per-thread cache-miss stall pulse |
| ev_trap | input | 4 | Per-thread trap stall pulse |
| ev_conflict | input | 4 | Per-thread resource-conflict stall pulse |
| op_start | input | 4 | Per-thread long-latency operation start pulse |
| op_done | input | 4 | Per-thread completion pulse; clears the block |
| advance | input | 1 | Pipeline advances this cycle; commits the age update |
| sel_onehot | output | 4 | One-hot selected thread, zero when none |
| sel_valid | output | 1 | A thread is selected this cycle |

## Verification
The selection responds to ready bits and block events in the same cycle, so the bench drives inputs at the falling edge and compares the outputs shortly after, before the next rising edge. An op_done, an advance and the age update only show up in the selection one rising edge later. The bench's reference model therefore applies those changes to its own state after the comparison, and the result is checked in the following cycle. Directed cases cover the reset order, rotation under continuous advance, holding without advance, event and completion in the same cycle, and the empty case with advance. Seeded random traffic then follows, with the selection compared in every cycle.

// File: rtl/mt_sel_pkg.sv
package mt_sel_pkg;
    localparam int NTHR = 4;
    localparam int TIDW = $clog2(NTHR);

    typedef logic [TIDW-1:0] tid_t;
    typedef logic [NTHR-1:0] tmask_t;
    // age list: entry 0 is the oldest, entry NTHR-1 the newest
    typedef logic [NTHR-1:0][TIDW-1:0] age_list_t;

    typedef struct packed {
        logic   valid;
        tmask_t onehot;
        tid_t   id;
    } pick_t;

    function automatic age_list_t initial_ages();
        age_list_t a;
        for (int k = 0; k < NTHR; k++) a[k] = tid_t'(k);
        return a;
    endfunction
endpackage

// File: rtl/mt_avail_track.sv
module mt_avail_track
    import mt_sel_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  tmask_t ready,
    input  tmask_t block_evt,
    input  tmask_t resume,
    output tmask_t avail
);
    tmask_t blk_q;

    always_ff @(posedge clk) begin
        if (rst) blk_q <= '0;
        else     blk_q <= (blk_q & ~resume) | block_evt;
    end

    // an event hides its thread in the cycle it arrives
    assign avail = ready & ~blk_q & ~block_evt;
endmodule

// File: rtl/mt_oldest_pick.sv
module mt_oldest_pick
    import mt_sel_pkg::*;
(
    input  age_list_t ages,
    input  tmask_t    avail,
    output pick_t     pick
);
    always_comb begin
        pick = '0;
        // scan newest to oldest; the last hit is the oldest available
        for (int k = NTHR - 1; k >= 0; k--) begin
            if (avail[ages[k]]) begin
                pick.valid  = 1'b1;
                pick.id     = ages[k];
                pick.onehot = tmask_t'(1) << ages[k];
            end
        end
    end
endmodule

// File: rtl/mt_age_list.sv
module mt_age_list
    import mt_sel_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      touch,
    input  tid_t      touch_id,
    output age_list_t ages
);
    age_list_t ages_q, ages_d;
    tid_t      pos;

    always_comb begin
        pos = '0;
        for (int k = 0; k < NTHR; k++)
            if (ages_q[k] == touch_id) pos = tid_t'(k);
    end

    always_comb begin
        ages_d = ages_q;
        if (touch) begin
            for (int k = 0; k < NTHR - 1; k++)
                ages_d[k] = (tid_t'(k) < pos) ? ages_q[k] : ages_q[k + 1];
            ages_d[NTHR - 1] = touch_id;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ages_q <= initial_ages();
        else     ages_q <= ages_d;
    end

    assign ages = ages_q;
endmodule

// File: rtl/mt_thread_picker.sv
module mt_thread_picker
    import mt_sel_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NTHR-1:0]  thr_ready,
    input  logic [NTHR-1:0]  ev_miss,
    input  logic [NTHR-1:0]  ev_trap,
    input  logic [NTHR-1:0]  ev_conflict,
    input  logic [NTHR-1:0]  op_start,
    input  logic [NTHR-1:0]  op_done,
    input  logic             advance,
    output logic [NTHR-1:0]  sel_onehot,
    output logic             sel_valid
);
    tmask_t    block_evt;
    tmask_t    avail;
    age_list_t ages;
    pick_t     pick;

    assign block_evt = ev_miss | ev_trap | ev_conflict | op_start;

    mt_avail_track u_avail (
        .clk       (clk),
        .rst       (rst),
        .ready     (thr_ready),
        .block_evt (block_evt),
        .resume    (op_done),
        .avail     (avail)
    );

    mt_oldest_pick u_pick (
        .ages  (ages),
        .avail (avail),
        .pick  (pick)
    );

    mt_age_list u_ages (
        .clk      (clk),
        .rst      (rst),
        .touch    (advance & pick.valid),
        .touch_id (pick.id),
        .ages     (ages)
    );

    assign sel_onehot = pick.onehot;
    assign sel_valid  = pick.valid;
endmodule

// File: rtl/mt_thread_picker_chk.sv
module mt_thread_picker_chk
    import mt_sel_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [NTHR-1:0] thr_ready,
    input logic [NTHR-1:0] ev_miss,
    input logic [NTHR-1:0] ev_trap,
    input logic [NTHR-1:0] ev_conflict,
    input logic [NTHR-1:0] op_start,
    input logic [NTHR-1:0] op_done,
    input logic            advance,
    input logic [NTHR-1:0] sel_onehot,
    input logic            sel_valid
);
    logic [NTHR-1:0] evt;
    assign evt = ev_miss | ev_trap | ev_conflict | op_start;

    a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel_onehot) && (sel_valid == (sel_onehot != '0)));

    a_r3_ready_only: assert property (@(posedge clk) disable iff (rst)
        (sel_onehot & ~thr_ready) == '0);

    a_r7_event_hides: assert property (@(posedge clk) disable iff (rst)
        (sel_onehot & evt) == '0);

    a_r8_empty: assert property (@(posedge clk) disable iff (rst)
        (thr_ready == '0) |-> (!sel_valid && sel_onehot == '0));

    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (!advance && evt == '0 && op_done == '0) ##1 ($stable(thr_ready) && evt == '0)
        |-> $stable(sel_onehot));
endmodule

bind mt_thread_picker mt_thread_picker_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .thr_ready   (thr_ready),
    .ev_miss     (ev_miss),
    .ev_trap     (ev_trap),
    .ev_conflict (ev_conflict),
    .op_start    (op_start),
    .op_done     (op_done),
    .advance     (advance),
    .sel_onehot  (sel_onehot),
    .sel_valid   (sel_valid)
);

// File: tb/mt_thread_picker_tb.sv
`timescale 1ns/1ps
module mt_thread_picker_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] thr_ready = '0, ev_miss = '0, ev_trap = '0, ev_conflict = '0;
    logic [3:0] op_start = '0, op_done = '0;
    logic       advance = 1'b0;
    logic [3:0] sel_onehot;
    logic       sel_valid;

    int n_checks = 0;
    int n_fail   = 0;

    // reference state
    int m_ord[4];
    bit m_blk[4];

    always #2.5 clk = ~clk;

    mt_thread_picker u_dut (
        .clk(clk), .rst(rst), .thr_ready(thr_ready), .ev_miss(ev_miss),
        .ev_trap(ev_trap), .ev_conflict(ev_conflict), .op_start(op_start),
        .op_done(op_done), .advance(advance), .sel_onehot(sel_onehot),
        .sel_valid(sel_valid)
    );

    function automatic void model_reset();
        for (int i = 0; i < 4; i++) begin
            m_ord[i] = i;
            m_blk[i] = 1'b0;
        end
    endfunction

    function automatic int model_pick(logic [3:0] rdy, logic [3:0] evt);
        for (int k = 0; k < 4; k++) begin
            int t = m_ord[k];
            if (rdy[t] && !m_blk[t] && !evt[t]) return t;
        end
        return -1;
    endfunction

    function automatic void model_update(int t, logic [3:0] evt, logic [3:0] done, logic adv);
        if (adv && t >= 0) begin
            int j = 0;
            int nord[4];
            for (int k = 0; k < 4; k++)
                if (m_ord[k] != t) begin nord[j] = m_ord[k]; j++; end
            nord[3] = t;
            m_ord = nord;
        end
        for (int i = 0; i < 4; i++)
            m_blk[i] = (m_blk[i] && !done[i]) || evt[i];
    endfunction

    task automatic step(input logic [3:0] rdy, input logic [3:0] miss,
                        input logic [3:0] trap, input logic [3:0] conf,
                        input logic [3:0] start, input logic [3:0] done,
                        input logic adv, input string tag);
        logic [3:0] evt;
        logic [3:0] exp_oh;
        logic       exp_v;
        int         t;
        @(negedge clk);
        thr_ready = rdy; ev_miss = miss; ev_trap = trap; ev_conflict = conf;
        op_start = start; op_done = done; advance = adv;
        #1;
        evt    = miss | trap | conf | start;
        t      = model_pick(rdy, evt);
        exp_v  = (t >= 0);
        exp_oh = exp_v ? (4'b0001 << t) : 4'b0000;
        n_checks++;
        if (sel_valid !== exp_v || sel_onehot !== exp_oh) begin
            n_fail++;
            $display("FAIL %s: actual valid=%b sel=%b expected valid=%b sel=%b",
                     tag, sel_valid, sel_onehot, exp_v, exp_oh);
        end
        model_update(t, evt, done, adv);
    endtask

    initial begin
        #(5.0 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual still running, expected finished");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset order, all ready, first pick is thread 0
        step(4'hF, 0, 0, 0, 0, 0, 1'b0, "R1");
        n_checks++;
        if (sel_onehot !== 4'b0001) begin
            n_fail++;
            $display("FAIL R1: actual sel=%b expected sel=0001", sel_onehot);
        end
        // R6: no advance keeps thread 0
        step(4'hF, 0, 0, 0, 0, 0, 1'b0, "R6");
        // R4 / R5: rotation under advance 0,1,2,3,0
        for (int c = 0; c < 5; c++) step(4'hF, 0, 0, 0, 0, 0, 1'b1, "R5");
        // R9: ready drop hides without blocking or aging
        step(4'b1101, 0, 0, 0, 0, 0, 1'b1, "R9");
        step(4'hF, 0, 0, 0, 0, 0, 1'b0, "R9");
        // R7: each event kind blocks; done releases one cycle later
        step(4'hF, 4'b0001, 4'b0010, 4'b0100, 0, 0, 1'b0, "R7");
        step(4'hF, 0, 0, 0, 0, 0, 1'b1, "R7");
        step(4'hF, 0, 0, 0, 4'b1000, 0, 1'b0, "R7");
        // R8: nothing available, advance must not age
        step(4'hF, 0, 0, 0, 0, 0, 1'b1, "R8");
        step(4'h0, 0, 0, 0, 0, 4'b0011, 1'b1, "R8");
        step(4'hF, 0, 0, 0, 0, 0, 1'b0, "R8");
        // R7: event and done together keep the block
        step(4'hF, 4'b0001, 0, 0, 0, 4'b0001, 1'b0, "R7");
        step(4'hF, 0, 0, 0, 0, 4'b1100, 1'b1, "R7");
        step(4'hF, 0, 0, 0, 0, 4'b0001, 1'b1, "R7");
        step(4'hF, 0, 0, 0, 0, 0, 1'b1, "R4");
        // R4 / R2 / R3: random traffic
        for (int c = 0; c < 3000; c++) begin
            logic [3:0] r, m, tr, cf, st, dn;
            r  = 4'($urandom) | 4'($urandom);
            m  = 4'($urandom) & 4'($urandom) & 4'($urandom);
            tr = 4'($urandom) & 4'($urandom) & 4'($urandom) & 4'($urandom);
            cf = 4'($urandom) & 4'($urandom) & 4'($urandom) & 4'($urandom);
            st = 4'($urandom) & 4'($urandom) & 4'($urandom);
            dn = 4'($urandom) & 4'($urandom);
            step(r, m, tr, cf, st, dn, 1'(($urandom % 4) != 0), "R4");
        end
        step(4'h0, 0, 0, 0, 0, 4'hF, 1'b1, "R2");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule